// File: doc/BRIEF.md
# Writemasked Vector Register Move Unit

This block is the datapath of a packed-integer vector move. It takes a source vector and the current value of the destination. The destination is either a vector register image or the memory image behind a store buffer. From these it builds the new destination value. A per-element writemask decides, for each element, whether the element is copied from the source, kept, or cleared. The element size, the active vector length, the masking mode and the operation form (register copy, load or store) select the granularity and the handling of masked-off elements. An encoding class (legacy, short-prefix or long-prefix) decides whether masking applies at all and what happens to the bits above the active length.

For the store form the unit also produces one write enable per byte. A memory interface can then update only the bytes the instruction writes. Memory operands need no alignment, so the unit has no address input and raises no alignment or protection fault. It checks one thing: the reserved register-specifier field of the prefixed encodings. A bad value raises an illegal-instruction fault and suppresses the write.

The unit has one register stage. A request presented with `valid_i` produces its result one cycle later with `valid_o`.

Top module: `vmask_move`

## Requirements
- R1: For long-prefix requests with the mask enabled, mask bit j controls element j. Element j covers bytes j*S to j*S+S-1, where S is the element size in bytes. The element size codes are 0=8, 1=16, 2=32 and 3=64 bits. An element whose mask bit is set is copied from `src_i`.
- R2: The vector length codes are 0=128, 1=256, 2=512 and 3=512 bits. Only the first (length / element size) mask bits are used. Mask bits at or above that count have no effect on `dst_o` or `be_o`. In the store form no byte enable is set at or above the active length.
- R3: A long-prefix request with `mask_en_i`=0 copies every element below the active length from `src_i`. Short-prefix and legacy requests ignore `mask_i`, `mask_en_i`, `zero_i` and `esz_i`.
- R4: The form codes are 0=register copy, 1=load, 2=store and 3=register copy. For long-prefix register-copy and load forms, a masked-off element keeps its `old_i` value when `zero_i`=0 and becomes zero when `zero_i`=1.
- R5: The store form never clears anything. Masked-off elements and bytes above the active length keep `old_i`, whatever `zero_i` is. `be_o` bit b is 1 exactly when byte b is written from `src_i`. `be_o` is all zero for every form other than store.
- R6: For long-prefix register-copy and load forms, `dst_o` bytes from the active length up to byte 63 are zero.
- R7: Short-prefix requests run at 128 bits for length code 0 and at 256 bits for any other code. The register-copy and load forms copy the active bytes and clear everything above them. The store form copies the active bytes and keeps everything above them.
- R8: Legacy requests always run at 128 bits, whatever the length code. They copy bytes 0 to 15 and keep `old_i` in bytes 16 to 63 for every form.
- R9: The encoding codes are 0=legacy, 1=short-prefix, 2=long-prefix and 3=long-prefix. A prefixed request with `vvvv_i` other than 4'b1111 sets `fault_o`, returns `old_i` unchanged on `dst_o` and clears `be_o`. Legacy requests never fault.
- R10: A request accepted with `valid_i`=1 shows its result on the next clock edge with `valid_o`=1. In a cycle with `valid_o`=0, `be_o` and `fault_o` are zero.
- R11: During reset, `valid_o` and `fault_o` are 0 and `be_o` and `dst_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| enc_i | input | 2 | Encoding class: 0 legacy, 1 short-prefix, 2/3 long-prefix |
| form_i | input | 2 | Operation form: 0/3 register copy, 1 load, 2 store |
| esz_i | input | 2 | Element size: 8 << esz_i bits |
| vlen_i | input | 2 | Vector length: 0 128, 1 256, 2/3 512 bits |
| mask_en_i | input | 1 | Writemask applied (long-prefix only) |
| zero_i | input | 1 | Zeroing instead of merging for masked-off elements |
| vvvv_i | input | 4 | Reserved register-specifier field, must be 4'b1111 |
| mask_i | input | 64 | Per-element writemask |
| src_i | input | 512 | Source vector |
| old_i | input | 512 | Current destination value |
| valid_o | output | 1 | Result valid |
| dst_o | output | 512 | New destination value |
| be_o | output | 64 | Per-byte write enables (store form) |
| fault_o | output | 1 | Illegal-encoding fault |

## Verification
Each result is computed from the current request alone, so the only state is the output register. Any wrong decode of granularity, length or mode shows up on `dst_o` or `be_o` in the cycle right after the request. A wrong element-to-byte mapping shows as a single misplaced byte at an element boundary. The sweep therefore uses asymmetric masks and distinct byte values in the source and old images. A fault path that leaks stale state shows in the same cycle as a changed `dst_o` or a nonzero `be_o`. Gating that leaks into idle cycles shows one cycle later as enables or a fault flag with `valid_o` low.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  localparam logic [1:0] ENC_LEGACY = 2'd0;
  localparam logic [1:0] ENC_SHORT  = 2'd1;
  localparam logic [1:0] FORM_STORE = 2'd2;
  localparam logic [3:0] VVVV_OK    = 4'hF;

  typedef struct packed {
    logic       store;
    logic       zero;
    logic       keep_upper;
    logic       mask_en;
    logic [1:0] esz;
    logic [6:0] vl_bytes;
  } vmask_ctl_t;
endpackage

// File: rtl/vmask_decode.sv
module vmask_decode
  import vmask_pkg::*;
(
  input  logic [1:0] enc_i,
  input  logic [1:0] form_i,
  input  logic [1:0] esz_i,
  input  logic [1:0] vlen_i,
  input  logic       mask_en_i,
  input  logic       zero_i,
  input  logic [3:0] vvvv_i,
  output vmask_ctl_t ctl_o,
  output logic       fault_o
);
  logic legacy, short_p, long_p;

  always_comb begin
    legacy  = (enc_i == ENC_LEGACY);
    short_p = (enc_i == ENC_SHORT);
    long_p  = !legacy && !short_p;

    ctl_o.store      = (form_i == FORM_STORE);
    ctl_o.keep_upper = legacy || ctl_o.store;
    ctl_o.mask_en    = long_p && mask_en_i;
    ctl_o.zero       = long_p && mask_en_i && zero_i && !ctl_o.store;
    ctl_o.esz        = esz_i;

    if (legacy || vlen_i == 2'd0) ctl_o.vl_bytes = 7'd16;
    else if (short_p || vlen_i == 2'd1) ctl_o.vl_bytes = 7'd32;
    else ctl_o.vl_bytes = 7'd64;

    fault_o = !legacy && (vvvv_i != VVVV_OK);
  end
endmodule

// File: rtl/vmask_byte_sel.sv
module vmask_byte_sel #(
  parameter int unsigned NBYTES = 64
) (
  input  logic              mask_en_i,
  input  logic [1:0]        esz_i,
  input  logic [6:0]        vl_bytes_i,
  input  logic [NBYTES-1:0] mask_i,
  output logic [NBYTES-1:0] act_o,
  output logic [NBYTES-1:0] sel_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int B = b;
    logic mbit;
    always_comb begin
      unique case (esz_i)
        2'd0:    mbit = mask_i[B];
        2'd1:    mbit = mask_i[B/2];
        2'd2:    mbit = mask_i[B/4];
        default: mbit = mask_i[B/8];
      endcase
      act_o[b] = 7'(B) < vl_bytes_i;
      sel_o[b] = act_o[b] && (!mask_en_i || mbit);
    end
  end
endmodule

// File: rtl/vmask_blend.sv
module vmask_blend #(
  parameter int unsigned NBYTES = 64
) (
  input  logic                  store_i,
  input  logic                  zero_i,
  input  logic                  keep_upper_i,
  input  logic [NBYTES-1:0]     act_i,
  input  logic [NBYTES-1:0]     sel_i,
  input  logic [NBYTES*8-1:0]   src_i,
  input  logic [NBYTES*8-1:0]   old_i,
  output logic [NBYTES*8-1:0]   dst_o,
  output logic [NBYTES-1:0]     be_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      if (sel_i[b])      dst_o[b*8 +: 8] = src_i[b*8 +: 8];
      else if (act_i[b]) dst_o[b*8 +: 8] = zero_i ? 8'h00 : old_i[b*8 +: 8];
      else               dst_o[b*8 +: 8] = keep_upper_i ? old_i[b*8 +: 8] : 8'h00;
      be_o[b] = store_i && sel_i[b];
    end
  end
endmodule

// File: rtl/vmask_move.sv
module vmask_move
  import vmask_pkg::*;
#(
  parameter int unsigned VMAX_W = 512,
  localparam int unsigned NBYTES = VMAX_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        enc_i,
  input  logic [1:0]        form_i,
  input  logic [1:0]        esz_i,
  input  logic [1:0]        vlen_i,
  input  logic              mask_en_i,
  input  logic              zero_i,
  input  logic [3:0]        vvvv_i,
  input  logic [NBYTES-1:0] mask_i,
  input  logic [VMAX_W-1:0] src_i,
  input  logic [VMAX_W-1:0] old_i,
  output logic              valid_o,
  output logic [VMAX_W-1:0] dst_o,
  output logic [NBYTES-1:0] be_o,
  output logic              fault_o
);
  vmask_ctl_t        ctl;
  logic              fault;
  logic [NBYTES-1:0] act, sel, be_nxt;
  logic [VMAX_W-1:0] dst_nxt;

  vmask_decode u_decode (
    .enc_i(enc_i), .form_i(form_i), .esz_i(esz_i), .vlen_i(vlen_i),
    .mask_en_i(mask_en_i), .zero_i(zero_i), .vvvv_i(vvvv_i),
    .ctl_o(ctl), .fault_o(fault)
  );

  vmask_byte_sel #(.NBYTES(NBYTES)) u_sel (
    .mask_en_i(ctl.mask_en), .esz_i(ctl.esz), .vl_bytes_i(ctl.vl_bytes),
    .mask_i(mask_i), .act_o(act), .sel_o(sel)
  );

  vmask_blend #(.NBYTES(NBYTES)) u_blend (
    .store_i(ctl.store), .zero_i(ctl.zero), .keep_upper_i(ctl.keep_upper),
    .act_i(act), .sel_i(sel), .src_i(src_i), .old_i(old_i),
    .dst_o(dst_nxt), .be_o(be_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      be_o    <= '0;
      dst_o   <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= valid_i && fault;
      be_o    <= (valid_i && !fault) ? be_nxt : '0;
      if (valid_i) dst_o <= fault ? old_i : dst_nxt;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (be_o == '0 && !fault_o)); // R10

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_i != ENC_LEGACY && vvvv_i != VVVV_OK)
    |=> (fault_o && be_o == '0 && dst_o == $past(old_i))); // R9

  AST_LEGACY_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_i == ENC_LEGACY)
    |=> (!fault_o && dst_o[VMAX_W-1:128] == $past(old_i[VMAX_W-1:128]))); // R8

  AST_BE_STORE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && form_i != FORM_STORE) |=> (be_o == '0)); // R5

  AST_BE_SHORT_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i == 2'd0) |=> (be_o[NBYTES-1:16] == '0)); // R2

  AST_LONG_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_i[1] && form_i != FORM_STORE && vlen_i == 2'd0 && vvvv_i == VVVV_OK)
    |=> (dst_o[VMAX_W-1:128] == '0)); // R6
endmodule

// File: tb/vmask_move_tb.sv
module vmask_move_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   enc_i = '0, form_i = '0, esz_i = '0, vlen_i = '0;
  logic         mask_en_i = 1'b0, zero_i = 1'b0;
  logic [3:0]   vvvv_i = 4'hF;
  logic [63:0]  mask_i = '0;
  logic [511:0] src_i = '0, old_i = '0;
  logic         valid_o, fault_o;
  logic [511:0] dst_o;
  logic [63:0]  be_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vmask_move dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .enc_i(enc_i), .form_i(form_i),
    .esz_i(esz_i), .vlen_i(vlen_i), .mask_en_i(mask_en_i), .zero_i(zero_i),
    .vvvv_i(vvvv_i), .mask_i(mask_i), .src_i(src_i), .old_i(old_i),
    .valid_o(valid_o), .dst_o(dst_o), .be_o(be_o), .fault_o(fault_o)
  );

  function automatic logic [63:0] pick_mask(input int k);
    case (k)
      0: return 64'h5555_5555_5555_5555;
      1: return 64'hF0F0_0FF0_3C3C_A5A5;
      2: return 64'h9E37_79B9_7F4A_7C15;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_0000_0006;
    endcase
  endfunction

  task automatic model(input logic [1:0] enc, input logic [1:0] form, input logic [1:0] esz,
                       input logic [1:0] vlen, input logic men, input logic zr,
                       input logic [3:0] vv, input logic [63:0] msk,
                       output logic [511:0] ed, output logic [63:0] eb, output logic ef);
    int vlb;
    int ebytes;
    bit lng, st, on;
    ebytes = 1 << esz;
    lng = (enc >= 2);
    st  = (form == 2'd2);
    if (enc == 2'd0) vlb = 16;
    else if (enc == 2'd1) vlb = (vlen == 2'd0) ? 16 : 32;
    else vlb = (vlen == 2'd0) ? 16 : (vlen == 2'd1) ? 32 : 64;
    ed = old_i;
    eb = '0;
    ef = (enc != 2'd0) && (vv != 4'hF);
    if (ef) return;
    if (!st && enc != 2'd0)
      for (int b = vlb; b < 64; b++) ed[b*8 +: 8] = 8'h00;
    for (int e = 0; e < vlb / ebytes; e++) begin
      on = !(lng && men) || msk[e];
      for (int k = 0; k < ebytes; k++) begin
        if (on) begin
          ed[(e*ebytes+k)*8 +: 8] = src_i[(e*ebytes+k)*8 +: 8];
          eb[e*ebytes+k] = st;
        end else if (!st && zr) begin
          ed[(e*ebytes+k)*8 +: 8] = 8'h00;
        end
      end
    end
  endtask

  task automatic xfer(input logic [1:0] enc, input logic [1:0] form, input logic [1:0] esz,
                      input logic [1:0] vlen, input logic men, input logic zr,
                      input logic [3:0] vv, input logic [63:0] msk, input string tag);
    logic [511:0] ed;
    logic [63:0]  eb;
    logic         ef;
    @(negedge clk);
    enc_i = enc; form_i = form; esz_i = esz; vlen_i = vlen;
    mask_en_i = men; zero_i = zr; vvvv_i = vv; mask_i = msk;
    valid_i = 1'b1;
    model(enc, form, esz, vlen, men, zr, vv, msk, ed, eb, ef);
    @(negedge clk);
    valid_i = 1'b0;
    total++;
    if (!valid_o || dst_o !== ed || be_o !== eb || fault_o !== ef) begin
      bad++;
      $display("FAIL %s enc=%0d form=%0d esz=%0d vlen=%0d men=%0d z=%0d: valid=%0d fault=%0d/%0d be=%h/%h dst=%h exp=%h",
               tag, enc, form, esz, vlen, men, zr, valid_o, fault_o, ef, be_o, eb, dst_o, ed);
    end
  endtask

  function automatic string tag_of(input logic [1:0] enc, input logic [1:0] form,
                                   input logic men, input logic zr);
    if (enc == 2'd0) return "R8";
    if (enc == 2'd1) return "R7 R3";
    if (form == 2'd2) return "R5";
    if (men && zr) return "R4 R1";
    if (men) return "R1 R4";
    return "R3 R6";
  endfunction

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 64; b++) begin
      src_i[b*8 +: 8] = 8'h80 | 8'(b);
      old_i[b*8 +: 8] = 8'h40 | 8'(b);
    end
    #23;
    total++;
    if (valid_o !== 1'b0 || fault_o !== 1'b0 || be_o !== '0 || dst_o !== '0) begin
      bad++;
      $display("FAIL R11 reset state valid=%0d fault=%0d be=%h dst=%h exp zero", valid_o, fault_o, be_o, dst_o);
    end
    rst_n = 1'b1;

    for (int enc = 0; enc < 3; enc++)
      for (int form = 0; form < 3; form++)
        for (int esz = 0; esz < 4; esz++)
          for (int vlen = 0; vlen < 3; vlen++)
            for (int men = 0; men < 2; men++)
              for (int zr = 0; zr < 2; zr++)
                for (int mk = 0; mk < 5; mk++)
                  xfer(2'(enc), 2'(form), 2'(esz), 2'(vlen), 1'(men), 1'(zr), 4'hF,
                       pick_mask(mk), tag_of(2'(enc), 2'(form), 1'(men), 1'(zr)));

    // R2: only mask bits above the element count set
    xfer(2'd2, 2'd0, 2'd3, 2'd0, 1'b1, 1'b1, 4'hF, 64'hFFFF_FFFF_FFFF_FFFC, "R2");
    xfer(2'd2, 2'd2, 2'd2, 2'd1, 1'b1, 1'b0, 4'hF, 64'hFFFF_FFFF_FFFF_FF00, "R2");
    xfer(2'd3, 2'd1, 2'd0, 2'd3, 1'b1, 1'b0, 4'hF, 64'h8000_0000_0000_0001, "R2 R4");
    xfer(2'd1, 2'd3, 2'd1, 2'd3, 1'b1, 1'b1, 4'hF, 64'h0, "R7 R3");

    // R9: bad reserved field on prefixed encodings, none on legacy
    for (int v = 0; v < 15; v++) begin
      xfer(2'd1, 2'd1, 2'd0, 2'd1, 1'b0, 1'b0, 4'(v), 64'hFFFF, "R9");
      xfer(2'd2, 2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 4'(v), 64'hFFFF_FFFF, "R9");
    end
    xfer(2'd0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1, 4'h0, 64'h0, "R9 R8");

    // R10: store with enables, then an idle cycle
    xfer(2'd2, 2'd2, 2'd0, 2'd2, 1'b0, 1'b0, 4'hF, 64'h0, "R10 R5");
    @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || be_o !== '0 || fault_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 idle after store valid=%0d be=%h fault=%0d exp 0/0/0", valid_o, be_o, fault_o);
    end
    xfer(2'd2, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 4'h3, 64'h0, "R10 R9");
    @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || be_o !== '0 || fault_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 idle after fault valid=%0d be=%h fault=%0d exp 0/0/0", valid_o, be_o, fault_o);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule